// File: doc/BRIEF.md
# Programmable Video Sync Generator

This block produces the horizontal and vertical sync levels for a video display. It runs a pixel counter across each line and a line counter down each frame. Software sets the frame size and the sync edge positions through a small register write port. Every sync edge is placed by comparing a 12-bit register with the running counters. The vertical sync edges are defined by a line and pixel coordinate pair, so an edge can fall in the middle of a line rather than only at a line start.

The block drives the sync levels and the live counter values to the display pipeline. Field-2 timing, blanking windows and pixel data handling are done elsewhere. Register writes take effect at the clock edge that accepts them. The counters never stall.

Top module: `syncgen_top`

## Requirements
- R1: While reset is held, both counters read 0 and both sync outputs are 0. The hsync register reads 0, and the frame register reads the default last-pixel and last-line indices.
- R2: The pixel counter steps by one each clock. In the clock after it equals or exceeds the last-pixel index, it returns to 0. The frame register (address 0) holds the last-pixel index, which is the frame width minus 1, in bits 11-0.
- R3: The line counter advances only in the clock where the pixel counter wraps. When a pixel wrap finds the line counter at or above the last-line index, the line counter returns to 0. The last-line index is held in frame register bits 27-16.
- R4: The hsync register is at address 1, with the start position in bits 11-0. The hsync output goes to 1 in the clock after the pixel counter equals the start position.
- R5: The hsync stop position is in bits 27-16 of the hsync register. The hsync output goes to 0 in the clock after the pixel counter equals the stop position. When start and stop are equal, the stop wins and hsync stays 0.
- R6: The vsync start register is at address 2, with the pixel coordinate in bits 11-0 and the line coordinate in bits 27-16. The vsync output goes to 1 in the clock after both counters match that pair in the same cycle.
- R7: The vsync stop register is at address 3 and uses the same field layout as address 2. The vsync output goes to 0 in the clock after both counters match the stop pair. When the start and stop pairs are equal, the stop wins.
- R8: In every register, bits 15-12 and 31-28 read as 0. Writing those bits has no effect on any field.
- R9: The frame width can be reduced while the pixel counter is already beyond the new last index. In that case the counter returns to 0 in the next clock and does not run on to its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address, used for both write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data of the addressed register |
| pixCount | output | 12 | Current pixel position within the line |
| lineCount | output | 12 | Current line position within the frame |
| hsyncOut | output | 1 | Horizontal sync level |
| vsyncOut | output | 1 | Vertical sync level |

## Verification
The hardest case to reach is a vsync edge that falls in the middle of a line. It needs the line and pixel counters to hit a programmed pair together, which takes a whole frame of clocks at display sizes. The bench therefore programs very small frames, a few tens of pixels by a few lines, with random vsync coordinates spread across the line. Each run lasts at least two full frames, so both vsync edges occur several times. Frame shrinks while the counter is out of range, and equal start and stop positions, are forced by directed writes timed on the observed pixel count.

// File: rtl/syncgen_pkg.sv
package syncgen_pkg;

  // Counter and register field width.
  localparam int unsigned CNT_W = 12;
  // Bit position of the upper field inside a 32-bit register.
  localparam int unsigned HI_LSB = 16;
  localparam int unsigned REG_W = 32;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned ADDR_W = $clog2(NUM_REGS);

  typedef enum logic [ADDR_W-1:0] {
    ADDR_FRAME  = 2'd0,
    ADDR_HSYNC  = 2'd1,
    ADDR_VSTART = 2'd2,
    ADDR_VSTOP  = 2'd3
  } regAddr_e;

  // Strobes from the compare logic to the datapath.
  typedef struct packed {
    logic pixWrap;
    logic lineWrap;
    logic hSet;
    logic hClr;
    logic vSet;
    logic vClr;
  } syncStrobe_t;

endpackage

// File: rtl/syncgen_ctrl.sv
module syncgen_ctrl
  import syncgen_pkg::*;
(
  input  logic [CNT_W-1:0] pixCount,
  input  logic [CNT_W-1:0] lineCount,
  input  logic [CNT_W-1:0] lastPix,
  input  logic [CNT_W-1:0] lastLine,
  input  logic [CNT_W-1:0] hStart,
  input  logic [CNT_W-1:0] hStop,
  input  logic [CNT_W-1:0] vStartX,
  input  logic [CNT_W-1:0] vStartY,
  input  logic [CNT_W-1:0] vStopX,
  input  logic [CNT_W-1:0] vStopY,
  output syncStrobe_t      strobe
);

  logic pixAtEnd;
  logic lineAtEnd;

  // ">=" lets a shrunk frame recover in one clock.
  assign pixAtEnd  = (pixCount >= lastPix);
  assign lineAtEnd = (lineCount >= lastLine);

  always_comb begin
    strobe          = '0;
    strobe.pixWrap  = pixAtEnd;
    strobe.lineWrap = pixAtEnd && lineAtEnd;
    strobe.hSet     = (pixCount == hStart);
    strobe.hClr     = (pixCount == hStop);
    strobe.vSet     = (lineCount == vStartY) && (pixCount == vStartX);
    strobe.vClr     = (lineCount == vStopY) && (pixCount == vStopX);
  end

endmodule

// File: rtl/syncgen_datapath.sv
module syncgen_datapath
  import syncgen_pkg::*;
#(
  parameter int unsigned DEF_LAST_PIX  = 799,
  parameter int unsigned DEF_LAST_LINE = 524
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wrData,
  input  syncStrobe_t          strobe,
  output logic [REG_W-1:0]     rdData,
  output logic [CNT_W-1:0]     pixCount,
  output logic [CNT_W-1:0]     lineCount,
  output logic [CNT_W-1:0]     lastPix,
  output logic [CNT_W-1:0]     lastLine,
  output logic [CNT_W-1:0]     hStart,
  output logic [CNT_W-1:0]     hStop,
  output logic [CNT_W-1:0]     vStartX,
  output logic [CNT_W-1:0]     vStartY,
  output logic [CNT_W-1:0]     vStopX,
  output logic [CNT_W-1:0]     vStopY,
  output logic                 hsyncOut,
  output logic                 vsyncOut
);

  localparam logic [CNT_W-1:0] RST_LO0 = CNT_W'(DEF_LAST_PIX);
  localparam logic [CNT_W-1:0] RST_HI0 = CNT_W'(DEF_LAST_LINE);
  localparam int unsigned RSV_W = HI_LSB - CNT_W;

  logic [CNT_W-1:0] cfgLo [NUM_REGS];
  logic [CNT_W-1:0] cfgHi [NUM_REGS];
  logic             unusedRsvBits;

  // Reserved data bits are never stored.
  assign unusedRsvBits = ^{wrData[HI_LSB-1:CNT_W], wrData[REG_W-1:HI_LSB+CNT_W]};

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : gRegs
    localparam logic [CNT_W-1:0] RST_LO = (gi == 0) ? RST_LO0 : '0;
    localparam logic [CNT_W-1:0] RST_HI = (gi == 0) ? RST_HI0 : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgLo[gi] <= RST_LO;
        cfgHi[gi] <= RST_HI;
      end else if (wrEn && (addr == ADDR_W'(gi))) begin
        cfgLo[gi] <= wrData[CNT_W-1:0];
        cfgHi[gi] <= wrData[HI_LSB+CNT_W-1:HI_LSB];
      end
    end
  end

  assign rdData = {{(REG_W-HI_LSB-CNT_W){1'b0}}, cfgHi[addr],
                   {RSV_W{1'b0}}, cfgLo[addr]};

  assign lastPix  = cfgLo[ADDR_FRAME];
  assign lastLine = cfgHi[ADDR_FRAME];
  assign hStart   = cfgLo[ADDR_HSYNC];
  assign hStop    = cfgHi[ADDR_HSYNC];
  assign vStartX  = cfgLo[ADDR_VSTART];
  assign vStartY  = cfgHi[ADDR_VSTART];
  assign vStopX   = cfgLo[ADDR_VSTOP];
  assign vStopY   = cfgHi[ADDR_VSTOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCount  <= '0;
      lineCount <= '0;
    end else if (strobe.pixWrap) begin
      pixCount  <= '0;
      lineCount <= strobe.lineWrap ? '0 : lineCount + 1'b1;
    end else begin
      pixCount  <= pixCount + 1'b1;
    end
  end

  // Clear has priority over set for both sync levels.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
    end else begin
      if (strobe.hClr)      hsyncOut <= 1'b0;
      else if (strobe.hSet) hsyncOut <= 1'b1;
      if (strobe.vClr)      vsyncOut <= 1'b0;
      else if (strobe.vSet) vsyncOut <= 1'b1;
    end
  end

endmodule

// File: rtl/syncgen_top.sv
module syncgen_top
  import syncgen_pkg::*;
#(
  parameter int unsigned DEF_LAST_PIX  = 799,
  parameter int unsigned DEF_LAST_LINE = 524
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic [11:0] pixCount,
  output logic [11:0] lineCount,
  output logic        hsyncOut,
  output logic        vsyncOut
);

  syncStrobe_t      strobe;
  logic [CNT_W-1:0] lastPix, lastLine, hStart, hStop;
  logic [CNT_W-1:0] vStartX, vStartY, vStopX, vStopY;

  syncgen_ctrl u_ctrl (
    .pixCount  (pixCount),
    .lineCount (lineCount),
    .lastPix   (lastPix),
    .lastLine  (lastLine),
    .hStart    (hStart),
    .hStop     (hStop),
    .vStartX   (vStartX),
    .vStartY   (vStartY),
    .vStopX    (vStopX),
    .vStopY    (vStopY),
    .strobe    (strobe)
  );

  syncgen_datapath #(
    .DEF_LAST_PIX  (DEF_LAST_PIX),
    .DEF_LAST_LINE (DEF_LAST_LINE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (regWrEn),
    .addr      (regAddr),
    .wrData    (regWrData),
    .strobe    (strobe),
    .rdData    (regRdData),
    .pixCount  (pixCount),
    .lineCount (lineCount),
    .lastPix   (lastPix),
    .lastLine  (lastLine),
    .hStart    (hStart),
    .hStop     (hStop),
    .vStartX   (vStartX),
    .vStartY   (vStartY),
    .vStopX    (vStopX),
    .vStopY    (vStopY),
    .hsyncOut  (hsyncOut),
    .vsyncOut  (vsyncOut)
  );

endmodule

// File: rtl/syncgen_checker.sv
module syncgen_checker (
  input logic        clk,
  input logic        rstN,
  input logic [11:0] pixCount,
  input logic [11:0] lineCount,
  input logic [11:0] lastPix,
  input logic [11:0] hStart,
  input logic [11:0] hStop,
  input logic [11:0] vStartX,
  input logic [11:0] vStartY,
  input logic [11:0] vStopX,
  input logic [11:0] vStopY,
  input logic        hsyncOut,
  input logic        vsyncOut
);

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pixCount != 12'd0) |-> (pixCount == $past(pixCount) + 12'd1)); // R2

  AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (pixCount >= lastPix) |=> (pixCount == 12'd0)); // R9

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pixCount != 12'd0) |-> $stable(lineCount)); // R3

  AST_HSYNC_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsyncOut) |-> ($past(pixCount) == $past(hStart))); // R4

  AST_HSYNC_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (pixCount == hStop) |=> !hsyncOut); // R5

  AST_VSYNC_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsyncOut) |-> (($past(pixCount) == $past(vStartX)) &&
                         ($past(lineCount) == $past(vStartY)))); // R6

  AST_VSYNC_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((pixCount == vStopX) && (lineCount == vStopY)) |=> !vsyncOut); // R7

endmodule

bind syncgen_top syncgen_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pixCount  (pixCount),
  .lineCount (lineCount),
  .lastPix   (lastPix),
  .hStart    (hStart),
  .hStop     (hStop),
  .vStartX   (vStartX),
  .vStartY   (vStartY),
  .vStopX    (vStopX),
  .vStopY    (vStopY),
  .hsyncOut  (hsyncOut),
  .vsyncOut  (vsyncOut)
);

// File: tb/syncgen_top_tb.sv
module syncgen_top_tb;

  localparam int unsigned DEF_PIX  = 799;
  localparam int unsigned DEF_LINE = 524;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [11:0] pixCount, lineCount;
  logic        hsyncOut, vsyncOut;

  int checks = 0;
  int fails = 0;
  bit cmpEn = 1'b0;
  bit done = 1'b0;

  // Bench reference state, built from the requirements.
  logic [11:0] mLastPix, mLastLine, mHStart, mHStop;
  logic [11:0] mVStartX, mVStartY, mVStopX, mVStopY;
  logic [11:0] mPix, mLine;
  logic        mH, mV;

  always #4 clk = ~clk;

  syncgen_top #(.DEF_LAST_PIX(DEF_PIX), .DEF_LAST_LINE(DEF_LINE)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pixCount  (pixCount),
    .lineCount (lineCount),
    .hsyncOut  (hsyncOut),
    .vsyncOut  (vsyncOut)
  );

  function automatic logic [31:0] packRegs(input logic [11:0] hi, input logic [11:0] lo);
    return {4'h0, hi, 4'h0, lo};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLastPix <= 12'(DEF_PIX);  mLastLine <= 12'(DEF_LINE);
      mHStart <= '0; mHStop <= '0;
      mVStartX <= '0; mVStartY <= '0; mVStopX <= '0; mVStopY <= '0;
      mPix <= '0; mLine <= '0; mH <= 1'b0; mV <= 1'b0;
    end else begin
      if (mPix >= mLastPix) begin                       // R2 R9
        mPix  <= '0;
        mLine <= (mLine >= mLastLine) ? 12'd0 : mLine + 12'd1;  // R3
      end else begin
        mPix <= mPix + 12'd1;
      end
      if (mPix == mHStop) mH <= 1'b0;                   // R5
      else if (mPix == mHStart) mH <= 1'b1;             // R4
      if (mPix == mVStopX && mLine == mVStopY) mV <= 1'b0;          // R7
      else if (mPix == mVStartX && mLine == mVStartY) mV <= 1'b1;   // R6
      if (regWrEn) begin
        case (regAddr)
          2'd0: begin mLastPix <= regWrData[11:0]; mLastLine <= regWrData[27:16]; end
          2'd1: begin mHStart <= regWrData[11:0]; mHStop <= regWrData[27:16]; end
          2'd2: begin mVStartX <= regWrData[11:0]; mVStartY <= regWrData[27:16]; end
          default: begin mVStopX <= regWrData[11:0]; mVStopY <= regWrData[27:16]; end
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && cmpEn) begin
      check(pixCount == mPix, "R2", "pixCount", pixCount, mPix);
      check(lineCount == mLine, "R3", "lineCount", lineCount, mLine);
      check(hsyncOut == mH, "R4 R5", "hsyncOut", hsyncOut, mH);
      check(vsyncOut == mV, "R6 R7", "vsyncOut", vsyncOut, mV);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [31:0] rv;
    int hHigh;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pixCount == 0 && lineCount == 0, "R1", "counters in reset", pixCount, 0);
    check(!hsyncOut && !vsyncOut, "R1", "syncs in reset", {hsyncOut, vsyncOut}, 0);
    rd(2'd1, rv);
    check(rv == 32'h0, "R1", "hsync reg reset", rv, 0);
    rd(2'd0, rv);
    check(rv == packRegs(12'(DEF_LINE), 12'(DEF_PIX)), "R1", "frame reg reset",
          rv, packRegs(12'(DEF_LINE), 12'(DEF_PIX)));
    @(negedge clk);
    rstN = 1'b1;
    cmpEn = 1'b1;

    // Directed small frame, vsync edges in mid-line.
    wr(2'd0, packRegs(12'd7, 12'd19));
    wr(2'd1, packRegs(12'd12, 12'd3));
    wr(2'd2, packRegs(12'd2, 12'd5));
    wr(2'd3, packRegs(12'd4, 12'd10));
    repeat (400) @(negedge clk);

    // R5: equal start and stop keep hsync low.
    wr(2'd1, packRegs(12'd6, 12'd6));
    repeat (25) @(negedge clk);
    hHigh = 0;
    repeat (60) begin
      @(negedge clk);
      if (hsyncOut) hHigh++;
    end
    check(hHigh == 0, "R5", "hsync high cycles with start==stop", hHigh, 0);

    // R7: equal vsync pairs keep vsync low.
    wr(2'd2, packRegs(12'd1, 12'd4));
    wr(2'd3, packRegs(12'd1, 12'd4));
    repeat (200) @(negedge clk);
    check(vsyncOut == 1'b0, "R7", "vsync with start==stop", vsyncOut, 0);

    // R8: reserved bits read 0 and leave fields intact.
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, rv);
    check(rv == 32'h0FFF_0FFF, "R8", "hsync reg after all-ones", rv, 32'h0FFF_0FFF);
    wr(2'd2, 32'hA005_5003);
    rd(2'd2, rv);
    check(rv == 32'h0005_0003, "R8", "vstart reg reserved", rv, 32'h0005_0003);

    // R9: shrink the frame while the counter is past the new end.
    wr(2'd0, packRegs(12'd3, 12'd40));
    while (pixCount != 12'd30) @(negedge clk);
    wr(2'd0, packRegs(12'd3, 12'd9));
    check(pixCount == 12'd31, "R9", "pix after shrink write", pixCount, 31);
    @(negedge clk);
    check(pixCount == 12'd0, "R9", "pix wrapped after shrink", pixCount, 0);

    // Random frames and sync positions.
    for (int it = 0; it < 8; it++) begin
      logic [11:0] lp, ll;
      lp = 12'(8 + $urandom_range(32));
      ll = 12'(2 + $urandom_range(8));
      wr(2'd0, packRegs(ll, lp));
      wr(2'd1, packRegs(12'($urandom_range(lp)), 12'($urandom_range(lp))));
      wr(2'd2, packRegs(12'($urandom_range(ll)), 12'($urandom_range(lp))));
      wr(2'd3, packRegs(12'($urandom_range(ll)), 12'($urandom_range(lp))));
      repeat (2 * (int'(lp) + 1) * (int'(ll) + 1) + 50) @(negedge clk);
    end
    finishRun();
  end

endmodule